// File: doc/BRIEF.md
# UDP/IPv4 Datagram Header Word Generator

This block builds the link, network and transport headers that go in front of one outgoing UDP datagram. It sends them as a stream of 16-bit words toward the host data port of an Ethernet MAC, and the caller's payload words follow on the same stream. The caller supplies both hardware addresses, both IPv4 addresses, both UDP ports and the payload size in bytes, and then pulses `start`. The block captures every field in that cycle. It then offers the 21 header words one at a time under a valid/ready handshake, and pulses `done` once the last word has been accepted.

The block derives the IPv4 total length and the UDP length from the payload size. Both checksum fields go out as zero, because the MAC's offload engine fills them in. The block also presents the complete frame byte count without the FCS, which software splits into the two bytes of the MAC's transmit length registers. A payload too large for a single unfragmented datagram is refused with an error pulse.

Top module: `udp_hdr_gen`

## Requirements
- R1: After reset, `out_valid`, `done` and `len_err` are low and `frame_len` is zero.
- R2: Each word carries two consecutive header bytes, the earlier byte in bits 7:0. Bytes 0–5 are the destination MAC, most significant byte first. Bytes 6–11 are the source MAC in the same byte order. Bytes 12–13 are 0x08, 0x00.
- R3: Header bytes 14–15 are 0x45, 0x00. Bytes 18–19 are zero (identification). Bytes 20–21 are 0x40, 0x00. Byte 22 is 0x0F and byte 23 is 0x11. Bytes 24–25 are zero (IP checksum).
- R4: Bytes 16–17 hold payload length + 28, high byte first. Bytes 38–39 hold payload length + 8, high byte first. Bytes 40–41 are zero (UDP checksum).
- R5: Bytes 26–29 are the source IP and bytes 30–33 are the destination IP, both most significant byte first. Bytes 34–35 are the source port and bytes 36–37 the destination port, both high byte first.
- R6: From the cycle after an accepted `start`, `frame_len` equals payload length + 42. It holds that value until the next accepted `start`.
- R7: Exactly 21 words are sent, and one word advances per cycle in which `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: `done` is high for exactly one cycle, the cycle after the final word is accepted. In that cycle `out_valid` is low and the block is idle.
- R9: A `start` while the block is sending has no effect: the stream in progress and `frame_len` are unchanged.
- R10: A `start` with payload length above 1472 raises `len_err` for one cycle. No word is sent and `frame_len` is unchanged. A length of exactly 1472 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one header; fields below are captured in this cycle |
| dst_mac | input | 48 | Destination hardware address |
| src_mac | input | 48 | Source hardware address |
| src_ip | input | 32 | Source IPv4 address |
| dst_ip | input | 32 | Destination IPv4 address |
| src_port | input | 16 | UDP source port |
| dst_port | input | 16 | UDP destination port |
| payload_len | input | 16 | UDP payload size in bytes |
| out_data | output | 16 | Header word, earlier byte in the low half |
| out_valid | output | 1 | `out_data` holds a header word |
| out_ready | input | 1 | Downstream accepts the current word |
| done | output | 1 | One-cycle pulse after the last header word |
| len_err | output | 1 | One-cycle pulse for a refused oversize request |
| frame_len | output | 16 | Frame byte count for the MAC length registers |

## Verification
If the word index is corrupted, whole byte pairs appear at the wrong header offsets, or the stream ends after a number of words other than 21. The reassembled byte image shows this within the same datagram. If the stored length is wrong, the two length fields and `frame_len` drift apart together, and `frame_len` shows the error one cycle after `start`. A fault in the busy state shows either as a second `start` restarting the stream partway through, or as `done` failing to pulse exactly one cycle after the final handshake. Stalls are inserted on `out_ready`, so any advance of the word index without a handshake shows up as a changed word during a stall.

// File: rtl/udp_hdr_pkg.sv
package udp_hdr_pkg;
  localparam int BYTE_W        = 8;
  localparam int WORD_W        = 16;
  localparam int LEN_W         = 16;
  localparam int ETH_BYTES     = 14;
  localparam int IP_BYTES      = 20;
  localparam int UDP_BYTES     = 8;
  localparam int HDR_BYTES     = ETH_BYTES + IP_BYTES + UDP_BYTES;
  localparam int HDR_WORDS     = HDR_BYTES / 2;
  localparam int HDR_BITS      = HDR_BYTES * BYTE_W;
  localparam int IDX_W         = $clog2(HDR_WORDS);
  localparam int MAX_PAYLOAD   = 1472;

  typedef struct packed {
    logic [47:0]      dst_mac;
    logic [47:0]      src_mac;
    logic [31:0]      src_ip;
    logic [31:0]      dst_ip;
    logic [15:0]      src_port;
    logic [15:0]      dst_port;
    logic [LEN_W-1:0] ip_len;
    logic [LEN_W-1:0] udp_len;
  } hdr_fields_t;

  function automatic logic [LEN_W-1:0] calc_udp_len(input logic [LEN_W-1:0] pl);
    return pl + LEN_W'(UDP_BYTES);
  endfunction

  function automatic logic [LEN_W-1:0] calc_ip_len(input logic [LEN_W-1:0] pl);
    return calc_udp_len(pl) + LEN_W'(IP_BYTES);
  endfunction

  function automatic logic [LEN_W-1:0] calc_frame_len(input logic [LEN_W-1:0] pl);
    return calc_ip_len(pl) + LEN_W'(ETH_BYTES);
  endfunction

  // Byte n of the header lands in bits [8n+7:8n], so word k is bits [16k+15:16k].
  function automatic logic [HDR_BITS-1:0] pack_header(input hdr_fields_t f);
    logic [BYTE_W-1:0] b [HDR_BYTES];
    logic [HDR_BITS-1:0] v;
    for (int i = 0; i < 6; i++) begin
      b[i]     = f.dst_mac[47-8*i -: 8];
      b[6 + i] = f.src_mac[47-8*i -: 8];
    end
    b[12] = 8'h08; b[13] = 8'h00;
    b[14] = 8'h45; b[15] = 8'h00;
    b[16] = f.ip_len[15:8]; b[17] = f.ip_len[7:0];
    b[18] = 8'h00; b[19] = 8'h00;
    b[20] = 8'h40; b[21] = 8'h00;
    b[22] = 8'h0F; b[23] = 8'h11;
    b[24] = 8'h00; b[25] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      b[26 + i] = f.src_ip[31-8*i -: 8];
      b[30 + i] = f.dst_ip[31-8*i -: 8];
    end
    b[34] = f.src_port[15:8]; b[35] = f.src_port[7:0];
    b[36] = f.dst_port[15:8]; b[37] = f.dst_port[7:0];
    b[38] = f.udp_len[15:8];  b[39] = f.udp_len[7:0];
    b[40] = 8'h00; b[41] = 8'h00;
    for (int i = 0; i < HDR_BYTES; i++) v[8*i +: 8] = b[i];
    return v;
  endfunction
endpackage

// File: rtl/udp_len_calc.sv
module udp_len_calc
  import udp_hdr_pkg::*;
#(
  parameter int MAX_LEN = MAX_PAYLOAD
) (
  input  logic [LEN_W-1:0] payload_len,
  output logic [LEN_W-1:0] ip_len,
  output logic [LEN_W-1:0] udp_len,
  output logic [LEN_W-1:0] frame_len,
  output logic             too_long
);
  always_comb begin
    too_long  = payload_len > LEN_W'(MAX_LEN);
    udp_len   = calc_udp_len(payload_len);
    ip_len    = calc_ip_len(payload_len);
    frame_len = calc_frame_len(payload_len);
  end
endmodule

// File: rtl/udp_hdr_seq.sv
module udp_hdr_seq
  import udp_hdr_pkg::*;
#(
  parameter int WORDS = HDR_WORDS,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          reject,
  input  logic          out_ready,
  output logic          accept,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic          done,
  output logic          err
);
  logic beat, last_beat;

  always_comb begin
    accept    = start && !busy && !reject;
    beat      = busy && out_ready;
    last_beat = beat && (idx == IW'(WORDS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= last_beat;
      err  <= start && !busy && reject;
      if (accept) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (last_beat) begin
        busy <= 1'b0;
        idx  <= '0;
      end else if (beat) begin
        idx  <= idx + 1'b1;
      end
    end
  end

  // R7
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx <= IW'(WORDS - 1));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !out_ready |=> busy && $stable(idx));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/udp_hdr_word_sel.sv
module udp_hdr_word_sel
  import udp_hdr_pkg::*;
#(
  parameter int WORDS = HDR_WORDS,
  parameter int WW    = WORD_W,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic [WORDS*WW-1:0] hdr,
  input  logic [IW-1:0]       idx,
  output logic [WW-1:0]       word
);
  logic [WW-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_split
    assign words[g] = hdr[g*WW +: WW];
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < WORDS; k++)
      if (idx == IW'(k)) word = words[k];
  end
endmodule

// File: rtl/udp_hdr_gen.sv
module udp_hdr_gen
  import udp_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] dst_mac,
  input  logic [47:0] src_mac,
  input  logic [31:0] src_ip,
  input  logic [31:0] dst_ip,
  input  logic [15:0] src_port,
  input  logic [15:0] dst_port,
  input  logic [15:0] payload_len,
  output logic [15:0] out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        done,
  output logic        len_err,
  output logic [15:0] frame_len
);
  logic [LEN_W-1:0]    ip_len_c, udp_len_c, frame_len_c;
  logic                too_long;
  logic                accept, busy;
  logic [IDX_W-1:0]    idx;
  hdr_fields_t         fields_q;
  logic [HDR_BITS-1:0] hdr_vec;
  logic [LEN_W-1:0]    frame_len_q;

  udp_len_calc #(.MAX_LEN(MAX_PAYLOAD)) u_len (
    .payload_len (payload_len),
    .ip_len      (ip_len_c),
    .udp_len     (udp_len_c),
    .frame_len   (frame_len_c),
    .too_long    (too_long)
  );

  udp_hdr_seq #(.WORDS(HDR_WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .reject    (too_long),
    .out_ready (out_ready),
    .accept    (accept),
    .busy      (busy),
    .idx       (idx),
    .done      (done),
    .err       (len_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q    <= '0;
      frame_len_q <= '0;
    end else if (accept) begin
      fields_q.dst_mac  <= dst_mac;
      fields_q.src_mac  <= src_mac;
      fields_q.src_ip   <= src_ip;
      fields_q.dst_ip   <= dst_ip;
      fields_q.src_port <= src_port;
      fields_q.dst_port <= dst_port;
      fields_q.ip_len   <= ip_len_c;
      fields_q.udp_len  <= udp_len_c;
      frame_len_q       <= frame_len_c;
    end
  end

  assign hdr_vec = pack_header(fields_q);

  udp_hdr_word_sel #(.WORDS(HDR_WORDS), .WW(WORD_W)) u_sel (
    .hdr  (hdr_vec),
    .idx  (idx),
    .word (out_data)
  );

  assign out_valid = busy;
  assign frame_len = frame_len_q;

  // R7
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R8
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, len_err, out_valid}));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && start |=> $stable(frame_len));
  // R10
  err_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !out_valid && $stable(frame_len));
  // R6
  frame_len_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> frame_len == fields_q.ip_len + 16'd14);
endmodule

// File: tb/sim_udp_hdr_gen.sv
module sim_udp_hdr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 21;
  localparam int NB = 42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] dst_mac = '0, src_mac = '0;
  logic [31:0] src_ip = '0, dst_ip = '0;
  logic [15:0] src_port = '0, dst_port = '0, payload_len = '0;
  logic [15:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        done, len_err;
  logic [15:0] frame_len;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  udp_hdr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dst_mac(dst_mac), .src_mac(src_mac), .src_ip(src_ip), .dst_ip(dst_ip),
    .src_port(src_port), .dst_port(dst_port), .payload_len(payload_len),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .done(done), .len_err(len_err), .frame_len(frame_len)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string byte_req(input int i);
    if (i < 14) return "R2";
    if (i == 16 || i == 17 || i >= 38) return "R4";
    if (i >= 26) return "R5";
    return "R3";
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  task automatic set_fields(input logic [15:0] len);
    dst_mac  = {$urandom, $urandom};
    src_mac  = {$urandom, $urandom};
    src_ip   = $urandom;
    dst_ip   = $urandom;
    src_port = 16'($urandom);
    dst_port = 16'($urandom);
    payload_len = len;
  endtask

  // Sends one header; mode 0 always ready, 1 alternating, 2 random stalls.
  // inject >= 0 fires a second start with new fields at that word count (R9).
  task automatic run_frame(input logic [15:0] len, input int mode, input int inject);
    logic [7:0]  exp_b [NB];
    logic [7:0]  got_b [NB];
    logic [15:0] ipl, udl, fl;
    logic [15:0] held;
    bit          stalled;
    int          n, guard;
    @(negedge clk);
    set_fields(len);
    ipl = len + 16'd28; udl = len + 16'd8; fl = len + 16'd42;
    for (int i = 0; i < 6; i++) begin
      exp_b[i]     = dst_mac[47-8*i -: 8];
      exp_b[6+i]   = src_mac[47-8*i -: 8];
    end
    exp_b[12] = 8'h08; exp_b[13] = 8'h00; exp_b[14] = 8'h45; exp_b[15] = 8'h00;
    exp_b[16] = ipl[15:8]; exp_b[17] = ipl[7:0];
    exp_b[18] = 0; exp_b[19] = 0; exp_b[20] = 8'h40; exp_b[21] = 0;
    exp_b[22] = 8'h0F; exp_b[23] = 8'h11; exp_b[24] = 0; exp_b[25] = 0;
    for (int i = 0; i < 4; i++) begin
      exp_b[26+i] = src_ip[31-8*i -: 8];
      exp_b[30+i] = dst_ip[31-8*i -: 8];
    end
    exp_b[34] = src_port[15:8]; exp_b[35] = src_port[7:0];
    exp_b[36] = dst_port[15:8]; exp_b[37] = dst_port[7:0];
    exp_b[38] = udl[15:8]; exp_b[39] = udl[7:0]; exp_b[40] = 0; exp_b[41] = 0;
    start = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(frame_len == fl, "R6", "frame_len after start", frame_len, fl);
    chk(out_valid == 1'b1, "R7", "valid after start", out_valid, 1);
    n = 0; guard = 0; stalled = 0; held = '0;
    while (n < NW && guard < 400) begin
      guard++;
      if (stalled)
        chk(out_valid && out_data == held, "R7", "word held under stall", out_data, held);
      if (!out_valid) begin
        chk(0, "R7", "valid dropped early", n, NW);
        break;
      end
      if (inject >= 0 && n == inject) begin
        set_fields(len ^ 16'h0005);
        start = 1'b1;
      end else start = 1'b0;
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = guard[0];
        default: out_ready = 1'($urandom_range(0, 1));
      endcase
      if (out_ready) begin
        got_b[2*n]   = out_data[7:0];
        got_b[2*n+1] = out_data[15:8];
        n++;
        stalled = 0;
      end else begin
        stalled = 1;
        held = out_data;
      end
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(n == NW, "R7", "word count", n, NW);
    chk(done == 1'b1, "R8", "done after last word", done, 1);
    chk(out_valid == 1'b0, "R8", "idle after last word", out_valid, 0);
    chk(frame_len == fl, inject >= 0 ? "R9" : "R6", "frame_len held", frame_len, fl);
    for (int i = 0; i < NB; i++)
      chk(got_b[i] == exp_b[i], byte_req(i), $sformatf("byte %0d", i), got_b[i], exp_b[i]);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done is one cycle", done, 0);
    chk(out_valid == 1'b0, "R9", "no restart after stream", out_valid, 0);
  endtask

  task automatic check_reset();
    chk(out_valid == 0, "R1", "reset valid", out_valid, 0);
    chk(done == 0, "R1", "reset done", done, 0);
    chk(len_err == 0, "R1", "reset len_err", len_err, 0);
    chk(frame_len == 0, "R1", "reset frame_len", frame_len, 0);
  endtask

  task automatic check_oversize(input logic [15:0] len);
    logic [15:0] prev;
    @(negedge clk);
    prev = frame_len;
    set_fields(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(len_err == 1'b1, "R10", "len_err raised", len_err, 1);
    chk(out_valid == 1'b0, "R10", "no words on oversize", out_valid, 0);
    chk(frame_len == prev, "R10", "frame_len kept", frame_len, prev);
    @(negedge clk);
    chk(len_err == 1'b0, "R10", "len_err one cycle", len_err, 0);
    chk(out_valid == 1'b0, "R10", "still idle", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    run_frame(16'd964, 0, -1);
    run_frame(16'd0, 1, -1);
    run_frame(16'd1472, 2, -1);
    for (int t = 0; t < 6; t++)
      run_frame(16'($urandom_range(0, 1472)), t % 3, -1);
    run_frame(16'd300, 0, 5);
    run_frame(16'd77, 2, 19);
    check_oversize(16'd1473);
    check_oversize(16'hFFFF);
    run_frame(16'd1, 1, -1);
    finish_run();
  end
endmodule